// File: doc/BRIEF.md
# ECC Sector Verdict and Erased-Page Classifier

This block sits behind a hardware ECC decoder. It turns the decoder's per-sector result into a final verdict for the read path. The decoder supplies a failure flag (bit 7 of its status byte) and an error count (bits 5:0 of the same byte). These arrive on `stat_fail` and `stat_errs`, qualified by a one-cycle `stat_valid` strobe. If the decode succeeded, the block simply passes the error count on as the number of corrected bits.

A decode failure on a freshly erased sector is expected: an all-ones sector carries no valid check bytes. When the flag is set, the block therefore pulls the sector's 32-bit data words through a valid/ready stream and counts their zero bits.

- If the zero total stays small, the failure is treated as an erased sector with a few stuck bits. The block reports it as erased and requests that the sector be overwritten with 0xFF.
- Otherwise the block reports the sector as uncorrectable.
- Counting stops as soon as the total passes the decoder's error count. After that, the block only drains the remaining words of the sector, so that the stream stays aligned.

The control is a five-state machine:

- IDLE: waits for `stat_valid`. It goes to REPORT when the failure flag is clear, and to SCAN when it is set.
- SCAN: accepts words and accumulates zero bits. It goes to DECIDE on the last word, and to DRAIN on a word that pushes the total over the limit before the end.
- DRAIN: accepts and discards words. It goes to DECIDE on the last word.
- DECIDE: registers the verdict, then goes to REPORT.
- REPORT: presents the verdict for one cycle, then returns to IDLE.

Top module: `ecc_sector_judge`

## Requirements
- R1: After reset, `vrd_valid`, `fill_req` and `wd_ready` are 0 and `vrd_code` is 0.
- R2: A `stat_valid` accepted in IDLE with `stat_fail` = 0 yields, in the next cycle, `vrd_valid` = 1 with `vrd_code` = 2'b01 (ok) and `vrd_count` = `stat_errs`. No data words are accepted (`wd_ready` stays 0).
- R3: With `stat_fail` = 1, exactly SECTOR_WORDS (default 512) words are accepted through `wd_valid`/`wd_ready` before the verdict, and no verdict appears while words are being accepted.
- R4: If the saturated zero-bit total never exceeds `stat_errs`, the verdict is `vrd_code` = 2'b10 (erased) with `vrd_count` = 0. Every verdict other than ok carries `vrd_count` = 0.
- R5: If the zero-bit total exceeds both `stat_errs` and `cfg_strength` >> 1, the verdict is `vrd_code` = 2'b11 (uncorrectable).
- R6: If the zero-bit total exceeds `stat_errs` but not `cfg_strength` >> 1, the verdict is erased (2'b10).
- R7: Counting stops with the word that first brings the total above `stat_errs`. Later words of the sector are still accepted, but their zero bits do not change the verdict.
- R8: The zero-bit total saturates at 63. With `stat_errs` = 63, even a sector of all-zero words is judged erased.
- R9: `vrd_valid` is high for exactly one cycle per accepted status. `fill_req` is high only in that cycle, and only when the code is erased.
- R10: A `stat_valid` strobe that arrives while a sector is being scanned or drained is ignored. The verdict of the sector in progress is unchanged, and no second verdict is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_valid | input | 1 | Status strobe from the ECC decoder |
| stat_fail | input | 1 | Decode failure flag (status bit 7) |
| stat_errs | input | 6 | Decoder error count (status bits 5:0) |
| cfg_strength | input | 6 | Configured correction strength in bits (default use 24) |
| wd_valid | input | 1 | Sector data word valid |
| wd_data | input | 32 | Sector data word |
| wd_ready | output | 1 | Block accepts a data word |
| vrd_valid | output | 1 | One-cycle verdict strobe |
| vrd_code | output | 2 | 01 ok, 10 erased, 11 uncorrectable, 00 when idle |
| vrd_count | output | 6 | Corrected-bit count (nonzero only for ok) |
| fill_req | output | 1 | Request to overwrite the sector with 0xFF |

## Verification
Two events can fall in the same cycle: the first over-limit word and the natural end of the sector. When the word that first pushes the total past `stat_errs` is also the last word, the machine must go straight to DECIDE and not into DRAIN. The bench provokes this with a sector whose only zero bits sit in word 511. It judges the result by the verdict code and by checking that exactly 512 words were accepted with no hang. A second overlap is a new status strobe arriving mid-scan. It is injected during SCAN and judged by the single verdict that follows, which must match the original sector.

// File: rtl/ejc_pkg.sv
package ejc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_DECIDE,
        ST_REPORT
    } judge_state_e;

    localparam logic [1:0] CODE_NONE   = 2'b00;
    localparam logic [1:0] CODE_OK     = 2'b01;
    localparam logic [1:0] CODE_ERASED = 2'b10;
    localparam logic [1:0] CODE_UNCORR = 2'b11;

endpackage

// File: rtl/ejc_zero_count.sv
module ejc_zero_count #(
    parameter int WORD_W = 32,
    parameter int PC_W   = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [PC_W-1:0]   zeros_o
);

    logic [WORD_W-1:0] inv_bits;

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_inv
            assign inv_bits[b] = ~word_i[b];
        end
    endgenerate

    always_comb begin
        zeros_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            zeros_o = zeros_o + PC_W'(inv_bits[i]);
        end
    end

endmodule

// File: rtl/ejc_tally.sv
module ejc_tally #(
    parameter int IN_W  = 6,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_en_i,
    input  logic [IN_W-1:0]  add_val_i,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] sum_o
);

    localparam int SUM_W = ((CNT_W > IN_W) ? CNT_W : IN_W) + 1;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] total_q;
    logic [SUM_W-1:0] sum_full;

    always_comb begin
        sum_full = SUM_W'(total_q) + SUM_W'(add_val_i);
        if (sum_full > SUM_W'(MAXV)) begin
            sum_o = MAXV;
        end else begin
            sum_o = sum_full[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clear_i) begin
            total_q <= '0;
        end else if (add_en_i) begin
            total_q <= sum_o;
        end
    end

    assign total_o = total_q;

endmodule

// File: rtl/ejc_verdict.sv
module ejc_verdict #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] total_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [CNT_W-1:0] strength_i,
    output logic             uncorr_o
);

    logic [CNT_W-1:0] half_strength;
    logic             above_limit;
    logic             above_half;

    always_comb begin
        half_strength = strength_i >> 1;
        above_limit   = total_i > limit_i;
        above_half    = total_i > half_strength;
        uncorr_o      = above_limit && above_half;
    end

endmodule

// File: rtl/ecc_sector_judge.sv
module ecc_sector_judge
    import ejc_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int SECTOR_WORDS = 512,
    parameter int CNT_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_valid,
    input  logic              stat_fail,
    input  logic [CNT_W-1:0]  stat_errs,
    input  logic [CNT_W-1:0]  cfg_strength,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              vrd_valid,
    output logic [1:0]        vrd_code,
    output logic [CNT_W-1:0]  vrd_count,
    output logic              fill_req
);

    localparam int IDX_W = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
    localparam int PC_W  = $clog2(WORD_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_WORDS - 1);

    judge_state_e     state_q, state_d;
    logic [CNT_W-1:0] limit_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       code_q;
    logic [CNT_W-1:0] count_q;

    logic             start_accept;
    logic             take;
    logic             last_word;
    logic             over_limit;
    logic             is_uncorr;
    logic             tally_add;
    logic [PC_W-1:0]  word_zeros;
    logic [CNT_W-1:0] total_now;
    logic [CNT_W-1:0] total_next;

    assign start_accept = (state_q == ST_IDLE) && stat_valid;
    assign take         = wd_valid && wd_ready;
    assign last_word    = (idx_q == LAST_IDX);
    assign tally_add    = take && (state_q == ST_SCAN);
    assign over_limit   = total_next > limit_q;

    ejc_zero_count #(
        .WORD_W (WORD_W),
        .PC_W   (PC_W)
    ) i_zero_count (
        .word_i  (wd_data),
        .zeros_o (word_zeros)
    );

    ejc_tally #(
        .IN_W  (PC_W),
        .CNT_W (CNT_W)
    ) i_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_accept),
        .add_en_i  (tally_add),
        .add_val_i (word_zeros),
        .total_o   (total_now),
        .sum_o     (total_next)
    );

    ejc_verdict #(
        .CNT_W (CNT_W)
    ) i_verdict (
        .total_i    (total_now),
        .limit_i    (limit_q),
        .strength_i (cfg_strength),
        .uncorr_o   (is_uncorr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stat_valid) begin
                    state_d = stat_fail ? ST_SCAN : ST_REPORT;
                end
            end
            ST_SCAN: begin
                if (take) begin
                    if (last_word) begin
                        state_d = ST_DECIDE;
                    end else if (over_limit) begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (take && last_word) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            idx_q   <= '0;
            code_q  <= CODE_NONE;
            count_q <= '0;
        end else begin
            if (start_accept) begin
                limit_q <= stat_errs;
                idx_q   <= '0;
                if (!stat_fail) begin
                    code_q  <= CODE_OK;
                    count_q <= stat_errs;
                end
            end else if (take) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_DECIDE) begin
                code_q  <= is_uncorr ? CODE_UNCORR : CODE_ERASED;
                count_q <= '0;
            end
        end
    end

    // Output logic
    always_comb begin
        wd_ready  = 1'b0;
        vrd_valid = 1'b0;
        vrd_code  = CODE_NONE;
        vrd_count = '0;
        fill_req  = 1'b0;
        unique case (state_q)
            ST_SCAN, ST_DRAIN: wd_ready = 1'b1;
            ST_REPORT: begin
                vrd_valid = 1'b1;
                vrd_code  = code_q;
                vrd_count = count_q;
                fill_req  = (code_q == CODE_ERASED);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ejc_checker.sv
module ejc_checker
    import ejc_pkg::*;
#(
    parameter int SECTOR_WORDS = 512,
    parameter int CNT_W        = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_accept,
    input logic             stat_fail,
    input logic [CNT_W-1:0] stat_errs,
    input logic             wd_valid,
    input logic             wd_ready,
    input logic             vrd_valid,
    input logic [1:0]       vrd_code,
    input logic [CNT_W-1:0] vrd_count,
    input logic             fill_req
);

    localparam int SEEN_W = $clog2(SECTOR_WORDS + 1) + 1;

    logic [SEEN_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (start_accept) begin
            seen_q <= '0;
        end else if (wd_valid && wd_ready) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    p_ok_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_accept && !stat_fail) |=>
            (vrd_valid && vrd_code == CODE_OK && vrd_count == $past(stat_errs)));

    p_scan_full_sector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_valid && vrd_code != CODE_OK) |-> (seen_q == SEEN_W'(SECTOR_WORDS)));

    p_ready_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |-> !vrd_valid);

    p_no_fast_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_accept && stat_fail) |=> !vrd_valid);

    p_fail_count_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_valid && vrd_code != CODE_OK) |-> (vrd_count == '0));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |=> !vrd_valid);

    p_fill_erased_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (vrd_valid && vrd_code == CODE_ERASED));

endmodule

bind ecc_sector_judge ejc_checker #(
    .SECTOR_WORDS (SECTOR_WORDS),
    .CNT_W        (CNT_W)
) i_ejc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_accept (start_accept),
    .stat_fail    (stat_fail),
    .stat_errs    (stat_errs),
    .wd_valid     (wd_valid),
    .wd_ready     (wd_ready),
    .vrd_valid    (vrd_valid),
    .vrd_code     (vrd_code),
    .vrd_count    (vrd_count),
    .fill_req     (fill_req)
);

// File: tb/test_ecc_sector_judge.sv
module test_ecc_sector_judge;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_valid = 1'b0;
    logic        stat_fail = 1'b0;
    logic [5:0]  stat_errs = '0;
    logic [5:0]  cfg_strength = 6'd24;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_ready;
    logic        vrd_valid;
    logic [1:0]  vrd_code;
    logic [5:0]  vrd_count;
    logic        fill_req;

    int tests = 0;
    int fails = 0;
    logic [31:0] sec [0:N-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_sector_judge i_ecc_sector_judge (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_valid   (stat_valid),
        .stat_fail    (stat_fail),
        .stat_errs    (stat_errs),
        .cfg_strength (cfg_strength),
        .wd_valid     (wd_valid),
        .wd_data      (wd_data),
        .wd_ready     (wd_ready),
        .vrd_valid    (vrd_valid),
        .vrd_code     (vrd_code),
        .vrd_count    (vrd_count),
        .fill_req     (fill_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected {code, count} from the requirements
    function automatic logic [7:0] model(input logic fl, input logic [5:0] lim,
                                         input logic [5:0] str);
        int z;
        if (!fl) return {2'b01, lim};
        z = 0;
        for (int i = 0; i < N; i++) begin
            z += $countones(~sec[i]);
            if (z > 63) z = 63;
            if (z > int'(lim)) break;
        end
        if (z > int'(lim) && z > int'(str >> 1)) return {2'b11, 6'd0};
        return {2'b10, 6'd0};
    endfunction

    task automatic fill_ones();
        for (int i = 0; i < N; i++) sec[i] = 32'hFFFF_FFFF;
    endtask

    task automatic flip_random(input int n);
        for (int i = 0; i < n; i++) begin
            int w;
            int b;
            w = int'($urandom % N);
            b = int'($urandom % 32);
            sec[w][b] = 1'b0;
        end
    endtask

    task automatic run_case(input logic fl, input logic [5:0] lim, input logic [5:0] str,
                            input bit poke, input string req);
        logic [7:0] e;
        int k, nval, guard, first_at, fill_bad;
        bit got;
        logic [1:0] gc;
        logic [5:0] gn;
        logic gf;
        e = model(fl, lim, str);
        k = 0; nval = 0; guard = 0; first_at = 0; fill_bad = 0; got = 0;
        gc = '0; gn = '0; gf = 1'b0;
        @(negedge clk);
        cfg_strength = str;
        stat_fail = fl;
        stat_errs = lim;
        stat_valid = 1'b1;
        @(negedge clk);
        stat_valid = 1'b0;
        while (guard < 5000) begin
            guard++;
            if (vrd_valid) begin
                nval++;
                if (!got) first_at = guard;
                got = 1'b1;
                gc = vrd_code; gn = vrd_count; gf = fill_req;
            end else if (got) begin
                break;
            end
            if (fill_req && !vrd_valid) fill_bad++;
            wd_valid = 1'b0;
            if (wd_ready && k < N && ($urandom % 4) != 0) begin
                wd_valid = 1'b1;
                wd_data = sec[k];
                k++;
            end
            stat_valid = 1'b0;
            if (poke && guard == 20) begin
                stat_fail = 1'b0;
                stat_errs = 6'd5;
                stat_valid = 1'b1;   // R10: must be ignored mid-scan
            end
            @(negedge clk);
        end
        wd_valid = 1'b0;
        stat_valid = 1'b0;
        check(got, "R9 verdict seen", int'(got), 1);
        check(nval == 1, "R9 pulse width", nval, 1);
        check(gc == e[7:6], {req, " code"}, int'(gc), int'(e[7:6]));
        check(gn == e[5:0], {req, " count"}, int'(gn), int'(e[5:0]));
        check(gf == (e[7:6] == 2'b10), "R9 fill_req", int'(gf), int'(e[7:6] == 2'b10));
        check(fill_bad == 0, "R9 stray fill_req", fill_bad, 0);
        check(k == (fl ? N : 0), "R3 words accepted", k, fl ? N : 0);
        if (!fl) check(first_at == 1, "R2 latency", first_at, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC7_0123));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(vrd_valid == 1'b0, "R1 vrd_valid", int'(vrd_valid), 0);
        check(wd_ready == 1'b0, "R1 wd_ready", int'(wd_ready), 0);
        check(fill_req == 1'b0, "R1 fill_req", int'(fill_req), 0);
        check(vrd_code == 2'b00, "R1 vrd_code", int'(vrd_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wd_ready == 1'b0, "R1 wd_ready after release", int'(wd_ready), 0);

        // R2: clean decodes
        fill_ones();
        run_case(1'b0, 6'd0, 6'd24, 1'b0, "R2");
        run_case(1'b0, 6'd63, 6'd24, 1'b0, "R2");
        run_case(1'b0, 6'd17, 6'd24, 1'b0, "R2");

        // R4: erased sector, no zero bits, limit 0
        fill_ones();
        run_case(1'b1, 6'd0, 6'd24, 1'b0, "R4");
        // R4: few flips within the limit
        fill_ones();
        sec[3][0] = 1'b0; sec[100][7] = 1'b0; sec[200][31] = 1'b0; sec[511][15] = 1'b0;
        run_case(1'b1, 6'd5, 6'd24, 1'b0, "R4");

        // R7 / R6: limit 3, first word 5 zeros then all-zero words: stop early, erased
        for (int i = 0; i < N; i++) sec[i] = 32'h0000_0000;
        sec[0] = 32'hFFFF_FFE0;
        run_case(1'b1, 6'd3, 6'd24, 1'b0, "R7");

        // R5: 30 zeros with limit 20, strength 24
        fill_ones();
        for (int i = 0; i < 30; i++) sec[i * 7][i % 32] = 1'b0;
        run_case(1'b1, 6'd20, 6'd24, 1'b0, "R5");

        // R6: 8 zeros above limit 4 but not above 12
        fill_ones();
        sec[10] = 32'hFFFF_FF00;
        run_case(1'b1, 6'd4, 6'd24, 1'b0, "R6");

        // R3 / R5: over-limit word is the last word (early stop and end coincide)
        fill_ones();
        sec[N-1] = 32'hFFFF_F800;
        run_case(1'b1, 6'd10, 6'd8, 1'b0, "R5");
        run_case(1'b1, 6'd10, 6'd24, 1'b0, "R6");

        // R8: saturation
        for (int i = 0; i < N; i++) sec[i] = 32'h0000_0000;
        run_case(1'b1, 6'd63, 6'd24, 1'b0, "R8");
        run_case(1'b1, 6'd62, 6'd24, 1'b0, "R8");

        // R10: status strobe during scan
        fill_ones();
        for (int i = 0; i < 20; i++) sec[i * 3][i] = 1'b0;
        run_case(1'b1, 6'd15, 6'd24, 1'b1, "R10");
        fill_ones();
        sec[5] = 32'hFFFF_0000;
        run_case(1'b1, 6'd2, 6'd24, 1'b1, "R10");

        // Random mix
        for (int t = 0; t < 30; t++) begin
            logic fl;
            logic [5:0] lim;
            logic [5:0] str;
            fl  = $urandom % 4 != 0;
            lim = 6'($urandom % 40);
            str = 6'($urandom % 49);
            fill_ones();
            flip_random(int'($urandom % 45));
            run_case(fl, lim, str, ($urandom % 5) == 0, "R5 R6 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule